// File: doc/BRIEF.md
# Interrupt Priority Resolver with Offload Routing

This block sits between a set of interrupt sources and a processor core. Hardware events set pending bits. The block qualifies each pending bit with a per-source enable bit and an offload-select bit. It then picks one winner for each of two service paths. The first path is a standard path, where software runs a routine. The second is an offload path, where a hardware transaction engine performs the service instead of software.

A standard winner is presented with its index on a vector read port. The 16-bit vector that comes back is turned into a service address in the upper memory page. An offload winner is presented with its index to the transaction engine.

Offload service always takes precedence over standard service. When the engine reports that a transfer has finished, the block returns that source to the standard path through a handback bit. Software configures the enable, select and handback registers through a small write port and can read all four registers back.

Top module: `irq_offload_resolver`

## Requirements
- R1: After reset both request outputs are low and the pending, enable, select and handback registers all read zero.
- R2: A source whose enable bit is 0 stays pending and is never serviced. The four top indices are always enabled and ignore their enable bits: NSRC-1 is the nonmaskable interrupt, NSRC-2 is stack overflow, NSRC-3 is the software trap and NSRC-4 is the unimplemented opcode.
- R3: Among the candidates of one path, the highest source index wins, so the nonmaskable interrupt (index NSRC-1) has the highest priority.
- R4: A standard request is issued only while the global enable `gie` is 1. Sources that arrive while `gie` is 0 stay pending and are served once `gie` returns to 1.
- R5: A source that is pending, enabled and has its select bit set goes to the offload path when `ofl_en` is 1. When `ofl_en` is 0, such a source is held pending and neither path serves it.
- R6: Sources NSRC-1 and NSRC-2 are never offloaded. Even with their select bits set they are served on the standard path.
- R7: When offload and standard candidates exist together, the offload request is issued first. No new standard request starts while an offload is requested or still running, that is, until `ofl_done`.
- R8: An offload request may be issued while a standard request is waiting for its acknowledge (preemption).
- R9: When `ofl_done` is asserted while an offload is running, the select bit of that source is cleared and its handback bit is set. A set handback bit is a standard candidate for the same index, and accepting it clears the handback bit.
- R10: While `std_req` is 1, `svc_addr` equals VEC_BASE (default 0xFF0000) plus the zero-extended `vec_data` fetched for `vec_idx`.
- R11: The index on each path is registered and held stable, with its request high, until that path is acknowledged. This holds even if a higher-priority source arrives in the meantime.
- R12: An acknowledge clears the accepted source's pending bit. If `req_set` sets the same bit in the same cycle, the bit stays set and is served again.
- R13: A write with `cfg_we` high updates one register on the next clock edge, chosen by `cfg_sel`: 0 selects enable, 1 selects offload-select, 2 selects handback, and 3 is ignored. A write takes precedence over any hardware update to the same register in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_set | input | NSRC | One-cycle event pulses that set pending bits |
| gie | input | 1 | Global enable for standard service |
| ofl_en | input | 1 | Enable for the offload path |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 enable, 1 select, 2 handback |
| cfg_wdata | input | NSRC | Register write data |
| pend_o | output | NSRC | Pending register readback |
| mask_o | output | NSRC | Enable register readback |
| sel_o | output | NSRC | Offload-select register readback |
| hback_o | output | NSRC | Handback register readback |
| std_req | output | 1 | Standard request valid |
| std_ack | input | 1 | Standard request accepted |
| vec_idx | output | log2(NSRC) | Winning standard index, also the vector read address |
| vec_data | input | VW | 16-bit vector for `vec_idx` |
| svc_addr | output | AW | Service routine address |
| ofl_req | output | 1 | Offload request valid |
| ofl_ack | input | 1 | Offload request accepted |
| ofl_idx | output | log2(NSRC) | Winning offload index |
| ofl_done | input | 1 | Offload transfer finished |

## Verification
The assertions check several rules on every cycle:
- each request, together with its index, is held stable until it is acknowledged;
- a standard request never starts without the global enable, or while an offload is requested or running;
- the two protected sources never reach the offload path;
- an event is never dropped from the pending register;
- an accepted handback bit is cleared.

Only the bench scenarios can show the complete service order:
- the priority order among several simultaneous sources;
- masked sources, and sources held by a disabled offload path, waiting and then being released;
- the full handback sequence after a transfer;
- an offload arriving while a standard request is outstanding;
- the address formed from each fetched vector.

// File: rtl/irq_offload_resolver.sv
module irq_offload_resolver #(
  parameter int NSRC = 16,
  parameter int VW = 16,
  parameter int AW = 24,
  parameter logic [AW-1:0] VEC_BASE = 24'hFF0000,
  localparam int IW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req_set,
  input  logic            gie,
  input  logic            ofl_en,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_sel,
  input  logic [NSRC-1:0] cfg_wdata,
  output logic [NSRC-1:0] pend_o,
  output logic [NSRC-1:0] mask_o,
  output logic [NSRC-1:0] sel_o,
  output logic [NSRC-1:0] hback_o,
  output logic            std_req,
  input  logic            std_ack,
  output logic [IW-1:0]   vec_idx,
  input  logic [VW-1:0]   vec_data,
  output logic [AW-1:0]   svc_addr,
  output logic            ofl_req,
  input  logic            ofl_ack,
  output logic [IW-1:0]   ofl_idx,
  input  logic            ofl_done
);

  localparam logic [NSRC-1:0] FIX_EN = {4'hF, {(NSRC-4){1'b0}}};
  localparam logic [NSRC-1:0] NO_OFL = {2'b11, {(NSRC-2){1'b0}}};

  typedef enum logic [1:0] {OFL_IDLE, OFL_REQ, OFL_RUN} ofl_st_t;

  logic [NSRC-1:0] pend_q, mask_q, sel_q, hback_q;
  logic [NSRC-1:0] en, sel_eff, ofl_cand, std_cand;
  logic [NSRC-1:0] clr_p, clr_h, set_h;
  logic            std_v;
  logic [IW-1:0]   std_idx_q, ofl_idx_q;
  ofl_st_t         ofl_st;
  logic            std_take, ofl_take, std_acc, ofl_acc;

  function automatic logic [IW-1:0] top_idx(input logic [NSRC-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int i = 0; i < NSRC; i++)
      if (v[i]) r = IW'(i);
    return r;
  endfunction

  assign en       = mask_q | FIX_EN;
  assign sel_eff  = sel_q & ~NO_OFL;
  assign ofl_cand = ofl_en ? (pend_q & en & sel_eff) : '0;
  assign std_cand = (pend_q & en & ~sel_eff) | hback_q;

  assign ofl_take = (ofl_st == OFL_IDLE) && (|ofl_cand);
  assign std_take = !std_v && gie && (|std_cand) && (ofl_st == OFL_IDLE) && !(|ofl_cand);
  assign std_acc  = std_v && std_ack;
  assign ofl_acc  = (ofl_st == OFL_REQ) && ofl_ack;

  assign clr_p = (std_acc ? (NSRC'(1) << std_idx_q) : '0) |
                 (ofl_acc ? (NSRC'(1) << ofl_idx_q) : '0);
  assign clr_h = std_acc ? (NSRC'(1) << std_idx_q) : '0;
  assign set_h = ((ofl_st == OFL_RUN) && ofl_done) ? (NSRC'(1) << ofl_idx_q) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q    <= '0;
      mask_q    <= '0;
      sel_q     <= '0;
      hback_q   <= '0;
      std_v     <= 1'b0;
      std_idx_q <= '0;
      ofl_idx_q <= '0;
      ofl_st    <= OFL_IDLE;
    end else begin
      pend_q <= (pend_q & ~clr_p) | req_set;

      if (cfg_we && cfg_sel == 2'd0) mask_q <= cfg_wdata;

      if (cfg_we && cfg_sel == 2'd1) sel_q <= cfg_wdata;
      else                           sel_q <= sel_q & ~set_h;

      if (cfg_we && cfg_sel == 2'd2) hback_q <= cfg_wdata;
      else                           hback_q <= (hback_q & ~clr_h) | set_h;

      case (ofl_st)
        OFL_IDLE: if (ofl_take) begin
          ofl_idx_q <= top_idx(ofl_cand);
          ofl_st    <= OFL_REQ;
        end
        OFL_REQ:  if (ofl_ack)  ofl_st <= OFL_RUN;
        OFL_RUN:  if (ofl_done) ofl_st <= OFL_IDLE;
        default:  ofl_st <= OFL_IDLE;
      endcase

      if (std_acc) std_v <= 1'b0;
      else if (std_take) begin
        std_v     <= 1'b1;
        std_idx_q <= top_idx(std_cand);
      end
    end
  end

  assign pend_o   = pend_q;
  assign mask_o   = mask_q;
  assign sel_o    = sel_q;
  assign hback_o  = hback_q;
  assign std_req  = std_v;
  assign vec_idx  = std_idx_q;
  assign svc_addr = VEC_BASE + AW'(vec_data);
  assign ofl_req  = (ofl_st == OFL_REQ);
  assign ofl_idx  = ofl_idx_q;

  AST_STD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    std_req && !std_ack |=> std_req && $stable(vec_idx)); // R11
  AST_OFL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ofl_req && !ofl_ack |=> ofl_req && $stable(ofl_idx)); // R11
  AST_STD_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(std_req) |-> $past(gie)); // R4
  AST_STD_AFTER_OFL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(std_req) |-> !$past(ofl_req) && $past(ofl_st) == OFL_IDLE); // R7
  AST_NO_OFL_PROTECTED: assert property (@(posedge clk) disable iff (!rst_n)
    ofl_req |-> int'(ofl_idx) < NSRC - 2); // R6
  AST_NO_LOST_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    |req_set |=> (pend_q & $past(req_set)) == $past(req_set)); // R12
  AST_HBACK_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    std_req && std_ack && !cfg_we && !ofl_done |=> !hback_q[$past(vec_idx)]); // R9

endmodule

// File: tb/test_irq_offload_resolver.sv
`timescale 1ns/1ps
module test_irq_offload_resolver;
  localparam int NSRC = 16;
  localparam int IW = 4;

  logic clk = 0, rst_n = 0;
  logic [NSRC-1:0] req_set = '0, cfg_wdata = '0;
  logic gie = 1, ofl_en = 1, cfg_we = 0;
  logic [1:0] cfg_sel = 0;
  logic [NSRC-1:0] pend_o, mask_o, sel_o, hback_o;
  logic std_req, std_ack = 0, ofl_req, ofl_ack = 0, ofl_done = 0;
  logic [IW-1:0] vec_idx, ofl_idx;
  logic [15:0] vec_data;
  logic [23:0] svc_addr;

  int n_chk = 0, n_fail = 0;
  bit hold_std = 0, finished = 0;
  int std_q[$];
  int ofl_q[$];

  always #2 clk = ~clk;

  function automatic logic [15:0] rom(input int i);
    return 16'h4000 + 16'(i * 16'h0111) + 16'h003C;
  endfunction
  assign vec_data = rom(int'(vec_idx));

  irq_offload_resolver i_irq_offload_resolver (
    .clk, .rst_n, .req_set, .gie, .ofl_en, .cfg_we, .cfg_sel, .cfg_wdata,
    .pend_o, .mask_o, .sel_o, .hback_o, .std_req, .std_ack, .vec_idx,
    .vec_data, .svc_addr, .ofl_req, .ofl_ack, .ofl_idx, .ofl_done);

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // monitor: pops expected items and acknowledges
  always @(negedge clk) begin
    if (rst_n) begin
      if (!hold_std) begin
        if (std_req && !std_ack) begin
          if (std_q.size() == 0)
            chk(0, "R3", "unexpected standard index", vec_idx, 0);
          else begin
            int e;
            e = std_q.pop_front();
            chk(int'(vec_idx) == e, "R3", "standard index", vec_idx, e);
            chk(svc_addr == 24'hFF0000 + 24'(rom(e)), "R10", "service address",
                svc_addr, 24'hFF0000 + 24'(rom(e)));
          end
          std_ack = 1;
        end else std_ack = 0;
      end
      if (ofl_req && !ofl_ack) begin
        if (ofl_q.size() == 0)
          chk(0, "R7", "unexpected offload index", ofl_idx, 0);
        else begin
          int e;
          e = ofl_q.pop_front();
          chk(int'(ofl_idx) == e, "R5", "offload index", ofl_idx, e);
        end
        ofl_ack = 1;
      end else ofl_ack = 0;
    end
  end

  task automatic pulse(input logic [NSRC-1:0] v);
    @(negedge clk) req_set = v;
    @(negedge clk) req_set = '0;
  endtask

  task automatic cfg(input logic [1:0] s, input logic [NSRC-1:0] d);
    @(negedge clk) begin cfg_we = 1; cfg_sel = s; cfg_wdata = d; end
    @(negedge clk) cfg_we = 0;
  endtask

  task automatic finish_ofl();
    @(negedge clk) ofl_done = 1;
    @(negedge clk) ofl_done = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic quiet(input string tag);
    int k;
    k = 0;
    while ((std_q.size() != 0 || ofl_q.size() != 0 || std_req || ofl_req || std_ack) && k < 300) begin
      @(negedge clk);
      k++;
    end
    chk(k < 300, tag, "queue drained", std_q.size() + ofl_q.size(), 0);
    idle(3);
    chk(!std_req && !ofl_req, tag, "no leftover request", {std_req, ofl_req}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    idle(3);
    @(negedge clk) rst_n = 1;
    idle(1);
    chk(!std_req && !ofl_req, "R1", "requests after reset", {std_req, ofl_req}, 0);
    chk(pend_o == 0 && mask_o == 0, "R1", "pending/enable after reset", {pend_o, mask_o}, 0);
    chk(sel_o == 0 && hback_o == 0, "R1", "select/handback after reset", {sel_o, hback_o}, 0);

    // R2: masked source stays pending; fixed-enable sources served
    pulse(16'h0008);
    idle(6);
    chk(!std_req, "R2", "masked source requested", std_req, 0);
    chk(pend_o[3], "R2", "masked source pending", pend_o[3], 1);
    std_q.push_back(15); std_q.push_back(13);
    pulse(16'hA000);
    quiet("R2");
    chk(pend_o == 16'h0008, "R12", "pending after ack", pend_o, 16'h0008);
    std_q.push_back(3);
    cfg(2'd0, 16'hFFFF);
    chk(mask_o == 16'hFFFF, "R13", "enable readback", mask_o, 16'hFFFF);
    quiet("R2");

    // R3: priority by index
    std_q.push_back(9); std_q.push_back(5); std_q.push_back(2);
    pulse(16'h0224);
    quiet("R3");
    chk(pend_o == 0, "R12", "pending cleared", pend_o, 0);

    // R4: global enable
    gie = 0;
    pulse(16'h0002);
    idle(6);
    chk(!std_req, "R4", "request with gie low", std_req, 0);
    chk(pend_o[1], "R4", "held pending", pend_o[1], 1);
    std_q.push_back(1);
    gie = 1;
    quiet("R4");

    // R7/R9: offload wins, handback follows
    cfg(2'd1, 16'h0010);
    chk(sel_o == 16'h0010, "R13", "select readback", sel_o, 16'h0010);
    ofl_q.push_back(4);
    std_q.push_back(6); std_q.push_back(4);
    pulse(16'h0050);
    idle(5);
    chk(ofl_q.size() == 0, "R7", "offload served first", ofl_q.size(), 0);
    chk(!std_req, "R7", "standard blocked during offload", std_req, 0);
    finish_ofl();
    chk(sel_o[4] == 0, "R9", "select cleared on done", sel_o[4], 0);
    chk(hback_o[4] == 1, "R9", "handback set on done", hback_o[4], 1);
    quiet("R9");
    chk(hback_o == 0, "R9", "handback cleared by service", hback_o, 0);

    // R5: select with offload disabled holds the source
    cfg(2'd1, 16'h0020);
    ofl_en = 0;
    pulse(16'h0020);
    idle(6);
    chk(!std_req && !ofl_req, "R5", "held with offload disabled", {std_req, ofl_req}, 0);
    chk(pend_o[5], "R5", "held pending", pend_o[5], 1);
    ofl_q.push_back(5);
    std_q.push_back(5);
    ofl_en = 1;
    idle(5);
    finish_ofl();
    quiet("R5");

    // R6: protected sources ignore select
    cfg(2'd1, 16'hC000);
    std_q.push_back(15); std_q.push_back(14);
    pulse(16'hC000);
    quiet("R6");
    chk(pend_o == 0, "R6", "protected sources served", pend_o, 0);

    // R8/R11: preemption and stable index
    cfg(2'd1, 16'h0010);
    hold_std = 1;
    pulse(16'h0080);
    idle(3);
    chk(std_req && vec_idx == 7, "R11", "standard waiting", vec_idx, 7);
    ofl_q.push_back(4);
    pulse(16'h0010);
    idle(4);
    chk(ofl_q.size() == 0, "R8", "offload issued during standard", ofl_q.size(), 0);
    chk(std_req && vec_idx == 7, "R8", "standard still waiting", vec_idx, 7);
    pulse(16'h1000);
    idle(3);
    chk(std_req && vec_idx == 7, "R11", "index held against higher source", vec_idx, 7);
    finish_ofl();
    std_q.push_back(7); std_q.push_back(12); std_q.push_back(4);
    hold_std = 0;
    quiet("R11");

    // R12: set in the same cycle as ack
    hold_std = 1;
    pulse(16'h0100);
    idle(3);
    chk(std_req && vec_idx == 8, "R12", "request for source 8", vec_idx, 8);
    @(negedge clk) begin std_ack = 1; req_set = 16'h0100; end
    @(negedge clk) begin std_ack = 0; req_set = '0; end
    chk(pend_o[8] == 1, "R12", "pending kept on set+clear", pend_o[8], 1);
    std_q.push_back(8);
    hold_std = 0;
    quiet("R12");
    chk(pend_o == 0, "R12", "pending cleared at end", pend_o, 0);

    // R13: handback write is a standard candidate; cfg_sel 3 ignored
    cfg(2'd3, 16'hFFFF);
    chk(mask_o == 16'hFFFF && sel_o == 16'h0000 && hback_o == 0, "R13", "select 3 ignored",
        {mask_o, sel_o, hback_o}, 48'hFFFF00000000);
    std_q.push_back(10);
    cfg(2'd2, 16'h0400);
    quiet("R13");

    finished = 1;
    summary();
    $finish;
  end
endmodule